// File: doc/BRIEF.md
# Security Register Serial Read Engine

This block is the slave-side front end of a serial flash for one command: reading the one-time-programmable security registers over a single-bit SPI link. While the chip select is low it collects an 8-bit command code, a 24-bit address and one filler byte from the serial input. It then returns bytes from one of three 1 KB register arrays on the serial output. The byte position advances after every byte and wraps inside the selected array. Streaming continues for as long as the host keeps the select low.

The serial pins are oversampled by a fast core clock. The array contents live in a small internal RAM that has a write port, so a testbench or a higher-level model can preload them. The output driver is modelled as a data bit plus an output-enable. The enable is low whenever the block is not returning data.

The middle address byte names the register, so the low address byte gives the starting byte inside the chosen register (0x000 to 0x0FF). Every location up to 0x3FF is reached by the increment and the wrap.

Top module: `sec_reg_reader`

## Requirements
- R1: A command is accepted only if its first 8 bits, taken MSB first on rising SCLK edges, equal 0x48. Any other code leaves so_oe low until cs_n goes high.
- R2: After the command code come 24 address bits (A23 first) and then 8 filler bits. Bit 7 of the first data byte is on `so` at the first SCLK falling edge after the 40th rising edge.
- R3: Data bits go out MSB first. `so` changes only in the core cycle that follows a detected SCLK falling edge.
- R4: A23–A16 = 0x00 with A15–A8 = 0x01, 0x02 or 0x03 selects register 1, 2 or 3. These are preload banks 0, 1 and 2.
- R5: The starting byte inside the selected register is A7–A0, and any value from 0x00 to 0xFF is accepted.
- R6: The byte position rises by one after each data byte and wraps from 0x3FF to 0x000 in the same register.
- R7: Data keeps streaming with no limit on the byte count until cs_n goes high.
- R8: so_oe is low while cs_n is high and during the command, address and filler phases. It goes low within a few core cycles after cs_n rises.
- R9: A rise of cs_n at any point abandons the command. The next low period starts again from the command code.
- R10: If A23–A16 is not 0x00, or A15–A8 is not 0x01 to 0x03, every data byte reads 0xFF.
- R11: While ld_en is high, a rising clk edge writes ld_data to byte ld_byte of bank ld_bank.
- R12: After rst_n is released, so_oe and so are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for `so` |
| ld_en | input | 1 | Preload write strobe |
| ld_bank | input | BANK_W | Preload bank (0 to BANKS-1) |
| ld_byte | input | BYTE_AW | Preload byte position |
| ld_data | input | 8 | Preload byte value |

## Verification
The bench goes after the wrap from 0x3FF to 0x000. A design that got it wrong would carry into the next register or read past the end of the array. Invalid address bytes must return 0xFF; a design that ignored A23–A16, or decoded A15–A8 too loosely, would return real data instead. The bench also checks that a first data bit lands exactly one edge after the filler byte, so an off-by-one phase count shows up as a shifted byte. It drops the select in the middle of the address and in the middle of data, then checks that the output is released and that the next command decodes cleanly. A wrong command code must never enable the output.

// File: rtl/sec_reg_pkg.sv
package sec_reg_pkg;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_ADDR,
      ST_DUMMY,
      ST_DATA,
      ST_SKIP
   } seq_state_t;

   localparam logic [7:0] FILL_BYTE = 8'hFF;

endpackage

// File: rtl/sec_reg_sync.sv
module sec_reg_sync #(
   parameter int               STAGES    = 2,
   parameter int               WIDTH     = 3,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RESET_VAL[g]}};
         else        chain <= {chain[STAGES-2:0], din[g]};
      end
      assign dout[g] = chain[STAGES-1];
   end

endmodule

// File: rtl/sec_reg_store.sv
module sec_reg_store #(
   parameter int BANKS   = 3,
   parameter int BYTE_AW = 10,
   parameter int BANK_W  = 2
) (
   input  logic               clk,
   input  logic               wr_en,
   input  logic [BANK_W-1:0]  wr_bank,
   input  logic [BYTE_AW-1:0] wr_byte,
   input  logic [7:0]         wr_data,
   input  logic [BANK_W-1:0]  rd_bank,
   input  logic [BYTE_AW-1:0] rd_byte,
   output logic [7:0]         rd_q
);

   localparam int DEPTH = BANKS << BYTE_AW;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en && int'(wr_bank) < BANKS) mem[{wr_bank, wr_byte}] <= wr_data;
      rd_q <= mem[{rd_bank, rd_byte}];
   end

endmodule

// File: rtl/sec_reg_seq.sv
module sec_reg_seq
   import sec_reg_pkg::*;
#(
   parameter int         BANKS   = 3,
   parameter int         BYTE_AW = 10,
   parameter int         BANK_W  = 2,
   parameter logic [7:0] OPCODE  = 8'h48
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_s,
   input  logic               cs_n_s,
   input  logic               si_s,
   input  logic [7:0]         rd_q,
   output logic [BANK_W-1:0]  rd_bank,
   output logic [BYTE_AW-1:0] rd_byte,
   output logic               so,
   output logic               so_oe,
   output seq_state_t         st,
   output logic               sclk_rise,
   output logic               sclk_fall,
   output logic               cs_act
);

   logic               sclk_d;
   logic [2:0]         bit_cnt;
   logic [1:0]         byte_cnt;
   logic [23:0]        sh;
   logic [23:0]        sh_n;
   logic [BYTE_AW-1:0] ptr;
   logic [BANK_W-1:0]  bank;
   logic               addr_ok;
   logic [7:0]         cur;
   logic               so_q;
   logic               oe_q;
   logic [7:0]         hi_b;
   logic [7:0]         mid_b;
   logic               sel_ok;
   logic [7:0]         next_byte;

   assign cs_act    = ~cs_n_s;
   assign sclk_rise = sclk_s & ~sclk_d;
   assign sclk_fall = ~sclk_s & sclk_d;
   assign sh_n      = {sh[22:0], si_s};
   assign hi_b      = sh_n[23:16];
   assign mid_b     = sh_n[15:8];
   assign sel_ok    = (hi_b == 8'h00) && (mid_b != 8'h00) && (int'(mid_b) <= BANKS);
   assign next_byte = addr_ok ? rd_q : FILL_BYTE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d   <= 1'b0;
         st       <= ST_CMD;
         bit_cnt  <= '0;
         byte_cnt <= '0;
         sh       <= '0;
         ptr      <= '0;
         bank     <= '0;
         addr_ok  <= 1'b0;
         cur      <= FILL_BYTE;
         so_q     <= 1'b0;
         oe_q     <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         if (!cs_act) begin
            st       <= ST_CMD;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            oe_q     <= 1'b0;
         end else if (sclk_rise) begin
            bit_cnt <= bit_cnt + 3'd1;
            unique case (st)
               ST_CMD: begin
                  sh <= sh_n;
                  if (bit_cnt == 3'd7) st <= (sh_n[7:0] == OPCODE) ? ST_ADDR : ST_SKIP;
               end
               ST_ADDR: begin
                  sh <= sh_n;
                  if (bit_cnt == 3'd7) begin
                     byte_cnt <= byte_cnt + 2'd1;
                     if (byte_cnt == 2'd2) begin
                        st      <= ST_DUMMY;
                        addr_ok <= sel_ok;
                        bank    <= sel_ok ? BANK_W'(mid_b - 8'd1) : '0;
                        ptr     <= BYTE_AW'(sh_n[7:0]);
                     end
                  end
               end
               ST_DUMMY, ST_DATA: begin
                  if (bit_cnt == 3'd7) begin
                     st  <= ST_DATA;
                     cur <= next_byte;
                     ptr <= ptr + 1'b1;
                  end
               end
               default: ;
            endcase
         end else if (sclk_fall && st == ST_DATA) begin
            so_q <= cur[~bit_cnt];
            oe_q <= 1'b1;
         end
      end
   end

   assign rd_bank = bank;
   assign rd_byte = ptr;
   assign so      = so_q;
   assign so_oe   = oe_q;

endmodule

// File: rtl/sec_reg_reader.sv
module sec_reg_reader
   import sec_reg_pkg::*;
#(
   parameter int         BANKS       = 3,
   parameter int         BYTE_AW     = 10,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] OPCODE      = 8'h48,
   localparam int        BANK_W      = (BANKS > 1) ? $clog2(BANKS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk,
   input  logic               cs_n,
   input  logic               si,
   output logic               so,
   output logic               so_oe,
   input  logic               ld_en,
   input  logic [BANK_W-1:0]  ld_bank,
   input  logic [BYTE_AW-1:0] ld_byte,
   input  logic [7:0]         ld_data
);

   if (BANKS < 1 || BANKS > 255) begin : g_bad_banks
      $error("BANKS must lie in 1..255");
   end
   if (BYTE_AW < 8 || BYTE_AW > 16) begin : g_bad_aw
      $error("BYTE_AW must lie in 8..16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [2:0]         pins_s;
   logic               sclk_rise;
   logic               sclk_fall;
   logic               cs_act;
   seq_state_t         st;
   logic [BANK_W-1:0]  rd_bank;
   logic [BYTE_AW-1:0] rd_byte;
   logic [7:0]         rd_q;

   sec_reg_sync #(
      .STAGES    (SYNC_STAGES),
      .WIDTH     (3),
      .RESET_VAL (3'b010)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({sclk, cs_n, si}),
      .dout  (pins_s)
   );

   sec_reg_store #(
      .BANKS   (BANKS),
      .BYTE_AW (BYTE_AW),
      .BANK_W  (BANK_W)
   ) u_store (
      .clk     (clk),
      .wr_en   (ld_en),
      .wr_bank (ld_bank),
      .wr_byte (ld_byte),
      .wr_data (ld_data),
      .rd_bank (rd_bank),
      .rd_byte (rd_byte),
      .rd_q    (rd_q)
   );

   sec_reg_seq #(
      .BANKS   (BANKS),
      .BYTE_AW (BYTE_AW),
      .BANK_W  (BANK_W),
      .OPCODE  (OPCODE)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s    (pins_s[2]),
      .cs_n_s    (pins_s[1]),
      .si_s      (pins_s[0]),
      .rd_q      (rd_q),
      .rd_bank   (rd_bank),
      .rd_byte   (rd_byte),
      .so        (so),
      .so_oe     (so_oe),
      .st        (st),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .cs_act    (cs_act)
   );

endmodule

// File: rtl/sec_reg_reader_chk.sv
module sec_reg_reader_chk
   import sec_reg_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       cs_act,
   input logic       sclk_fall,
   input logic       so,
   input logic       so_oe,
   input seq_state_t st
);

   // R8
   oe_off_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !so_oe);

   // R8
   oe_only_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(so_oe) |-> ($past(st) == ST_DATA));

   // R3
   so_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (so_oe && $past(so_oe) && !$past(sclk_fall)) |-> $stable(so));

   // R9
   abort_to_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (st == ST_CMD));

   // R1
   skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SKIP) |-> !so_oe);

endmodule

bind sec_reg_reader sec_reg_reader_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_act    (cs_act),
   .sclk_fall (sclk_fall),
   .so        (so),
   .so_oe     (so_oe),
   .st        (st)
);

// File: tb/tb_sec_reg_reader.sv
module tb_sec_reg_reader;

   localparam int HALF = 6;
   localparam int NVEC = 8;
   // address in [39:16], byte count in [15:0]
   localparam logic [39:0] VEC [NVEC] = '{
      {24'h000100, 16'd4},   // R4 R5 register 1 from byte 0
      {24'h000255, 16'd3},   // R4 register 2
      {24'h0003FE, 16'd4},   // R4 register 3
      {24'h0001FF, 16'd2},   // R5 top of start range
      {24'h000410, 16'd2},   // R10 middle byte too large
      {24'h010100, 16'd2},   // R10 upper byte nonzero
      {24'h000020, 16'd2},   // R10 middle byte zero
      {24'h000380, 16'd5}    // R6 increment across bytes
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0;
   logic       cs_n = 1'b1;
   logic       si = 1'b0;
   logic       so;
   logic       so_oe;
   logic       ld_en = 1'b0;
   logic [1:0] ld_bank = '0;
   logic [9:0] ld_byte = '0;
   logic [7:0] ld_data = '0;

   int  total = 0;
   int  bad = 0;
   bit  oe_seen;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   sec_reg_reader dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk    (sclk),
      .cs_n    (cs_n),
      .si      (si),
      .so      (so),
      .so_oe   (so_oe),
      .ld_en   (ld_en),
      .ld_bank (ld_bank),
      .ld_byte (ld_byte),
      .ld_data (ld_data)
   );

   function automatic logic [7:0] pat(int b, int i);
      return 8'((i * 37) ^ (b * 90) ^ (i >> 3));
   endfunction

   function automatic logic [7:0] expect_byte(logic [23:0] a, int k);
      if (a[23:16] != 8'h00 || a[15:8] == 8'h00 || a[15:8] > 8'h03) return 8'hFF;
      return pat(int'(a[15:8]) - 1, (int'(a[7:0]) + k) % 1024);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         si = tx[i];
         wait_clk(HALF);
         rx[i] = so;
         if (so_oe) oe_seen = 1'b1;
         sclk = 1'b1;
         wait_clk(HALF);
         sclk = 1'b0;
      end
   endtask

   task automatic load(int b, int i, logic [7:0] d);
      ld_en = 1'b1;
      ld_bank = 2'(b);
      ld_byte = 10'(i);
      ld_data = d;
      wait_clk(1);
      ld_en = 1'b0;
   endtask

   task automatic begin_cmd(logic [23:0] a);
      logic [7:0] rx;
      cs_n = 1'b0;
      oe_seen = 1'b0;
      wait_clk(HALF);
      xfer(8'h48, rx);
      xfer(a[23:16], rx);
      xfer(a[15:8], rx);
      xfer(a[7:0], rx);
      xfer(8'h00, rx);
      chk("R8 header oe", 32'(oe_seen), 32'd0);
   endtask

   task automatic end_cmd();
      cs_n = 1'b1;
      wait_clk(4 * HALF);
   endtask

   task automatic read_check(string req, logic [23:0] a, int n);
      logic [7:0] rx;
      for (int k = 0; k < n; k++) begin
         xfer(8'h00, rx);
         chk(req, 32'(rx), 32'(expect_byte(a, k)));
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] rx;
      wait_clk(5);
      chk("R12 oe in reset", 32'(so_oe), 32'd0);
      rst_n = 1'b1;
      wait_clk(3);
      chk("R12 oe after reset", 32'(so_oe), 32'd0);
      chk("R12 so after reset", 32'(so), 32'd0);

      // R11 preload every bank
      for (int b = 0; b < 3; b++)
         for (int i = 0; i < 1024; i++) load(b, i, pat(b, i));

      // table of vectors: R2 R4 R5 R10
      for (int v = 0; v < NVEC; v++) begin
         begin_cmd(VEC[v][39:16]);
         read_check("R2 R4 R5 R10 vector", VEC[v][39:16], int'(VEC[v][15:0]));
         end_cmd();
         chk("R8 oe after cs_n high", 32'(so_oe), 32'd0);
      end

      // R6 R7 long stream from 0x0FF of register 3 through the wrap
      begin_cmd(24'h0003FF);
      read_check("R6 R7 wrap stream", 24'h0003FF, 770);
      end_cmd();

      // R1 wrong command code keeps the output off
      cs_n = 1'b0;
      oe_seen = 1'b0;
      wait_clk(HALF);
      xfer(8'h0B, rx);
      for (int k = 0; k < 6; k++) xfer(8'h00, rx);
      chk("R1 bad opcode oe", 32'(oe_seen), 32'd0);
      end_cmd();

      // R9 abort inside the address, then a clean command
      cs_n = 1'b0;
      wait_clk(HALF);
      xfer(8'h48, rx);
      xfer(8'h00, rx);
      end_cmd();
      begin_cmd(24'h000210);
      read_check("R9 after address abort", 24'h000210, 2);
      end_cmd();

      // R8 R9 abort in the middle of a data byte
      begin_cmd(24'h000105);
      read_check("R9 before data abort", 24'h000105, 1);
      for (int i = 0; i < 3; i++) begin
         wait_clk(HALF);
         sclk = 1'b1;
         wait_clk(HALF);
         sclk = 1'b0;
      end
      cs_n = 1'b1;
      wait_clk(2 * HALF);
      chk("R8 oe after data abort", 32'(so_oe), 32'd0);
      wait_clk(2 * HALF);
      begin_cmd(24'h000300);
      read_check("R9 after data abort", 24'h000300, 2);
      end_cmd();

      // R11 overwrite one byte and read it back between neighbours
      load(1, 10'h020, 8'hC3);
      begin_cmd(24'h00021F);
      xfer(8'h00, rx);
      chk("R11 byte before", 32'(rx), 32'(pat(1, 10'h01F)));
      xfer(8'h00, rx);
      chk("R11 overwritten byte", 32'(rx), 32'hC3);
      xfer(8'h00, rx);
      chk("R11 byte after", 32'(rx), 32'(pat(1, 10'h021)));
      end_cmd();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule